// File: doc/BRIEF.md
# Converter serial register port with shared ready flag

This block is the device-side serial port of a conversion peripheral. A host frames each access with an active-low select, a serial clock that idles high, and a data input. Every access opens with an 8-bit command byte. That byte names an internal register and says whether the access reads or writes it. Read data leaves on one output pin. When no read is shifting, the same pin shows a conversion-ready flag, so its falling edge can serve as an interrupt to the host.

A behavioural stub outside the block supplies a conversion-done strobe with the result word, and an update-near strobe shortly before the next result is due. Inside the block sit a 16-bit mode register, a 16-bit configuration register, an 8-bit status register and the result register. The low four bits of the mode register select the mains-rejection rate. A decoded version of that field is brought out as a port.

The port state machine has four states. ST_CMD collects the command byte. ST_WRITE collects a 16-bit register write. ST_READ shifts a register out. ST_CONT waits, in continuous-read mode, for the next result.

The transitions are:
- ST_CMD to ST_READ when a read byte arrives.
- ST_CMD to ST_WRITE when a write byte to a writable register arrives.
- ST_CMD to ST_CMD when the byte is guarded or names a register that cannot be written.
- ST_WRITE to ST_CMD after the 16th data bit.
- ST_READ to ST_CMD or ST_CONT after the last bit has been sampled.
- ST_CONT to ST_READ on a falling serial-clock edge while a result is pending.
- Any state to ST_CMD when select rises or when the resync pattern arrives.

Top module: `conv_serial_port`

## Requirements
- R1: Serial input is sampled on rising serial-clock edges. Read data is driven on falling edges, most significant bit first, so the host samples each bit on the following rising edge. The first read bit follows the falling edge after the command byte's eighth rising edge.
- R2: With select low and no read shifting, `sdo` shows the ready flag. The flag is 1 after reset and goes to 0 once a conversion-done strobe has loaded a new result.
- R3: Reading the data register sets the ready flag to 1 when the read completes. Reading the status register leaves the flag unchanged. In normal mode the data register can be read again and returns the same word.
- R4: If the result is not read, an update-near strobe sets the ready flag back to 1.
- R5: A read of the data register with command bit 2 set enters continuous-read mode (ST_CONT). Each later result shifts out, RES_W bits, with no command byte. Each result is delivered once. Clocks given while the flag is 1 start no read, and `sdo` stays 1.
- R6: Command byte layout: bit 7 must be 0, otherwise the byte is ignored. Bit 6 is 1 for a read and 0 for a write. Bits 5:3 hold the address (0 status, 1 mode, 2 config, 3 data). Bit 2 is the continuous-read request.
- R7: The status register is 8 bits: bit 7 is the ready flag and bit 6 is the continuous-mode state. Writes to status, data or unused addresses are ignored and have no data phase, so the next byte is again a command.
- R8: The mode and configuration registers take 16-bit writes, most significant bit first, and read back what was written.
- R9: Mode bits 3:0 decode onto `rej_sel`: 1000 gives 1 (60 Hz), 1001 gives 2 (50 Hz), 1010 gives 3 (both), and every other code gives 0. After reset the mode register is 0x000A.
- R10: While select is high, `sdo_en` is 0 and a partial command or write is dropped. Registers keep their values. Continuous mode is kept.
- R11: Thirty-two consecutive rising edges with the data input at 1 return the port to ST_CMD and leave continuous-read mode.
- R12: The result word is RES_W bits of offset binary. It is passed from the conversion strobe to the port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low select; may be tied low |
| sclk | input | 1 | Serial clock, idles high, falling edge active |
| sdi | input | 1 | Serial data input |
| conv_done | input | 1 | One-cycle strobe: a new result is on conv_result |
| conv_result | input | RES_W | Offset-binary conversion result |
| update_near | input | 1 | One-cycle strobe: the next result update is close |
| sdo | output | 1 | Read data or ready flag (0 = ready) |
| sdo_en | output | 1 | Output enable for sdo; 0 means high impedance |
| rej_sel | output | 2 | Decoded rejection-rate selection from the mode register |

## Verification
A wrong state in the command decoder shows within a byte or two. A byte taken as a read when it should be ignored, or a data phase that is too long, makes the next command's read-back come out as the flag level or shifted by some bits. Errors in the ready flag show on `sdo` while idle, a few system clocks after the strobe or read that should have moved it. Continuous-mode errors show as a repeated word or a missing word on the next unframed 24 clocks. The bench sweeps all sixteen rate codes and several corner result patterns, and each check is made at the first bit time where the fault would be visible.

// File: rtl/csp_pkg.sv
package csp_pkg;
    typedef enum logic [1:0] {
        ST_CMD,
        ST_WRITE,
        ST_READ,
        ST_CONT
    } port_state_t;

    localparam logic [2:0] ADDR_STAT = 3'd0;
    localparam logic [2:0] ADDR_MODE = 3'd1;
    localparam logic [2:0] ADDR_CONF = 3'd2;
    localparam logic [2:0] ADDR_DATA = 3'd3;

    localparam int CFG_W  = 16;
    localparam int STAT_W = 8;
endpackage

// File: rtl/csp_pin_sync.sv
module csp_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= RST_VAL;
                else        pipe <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= {STAGES{RST_VAL}};
                else        pipe <= {pipe[STAGES-2:0], pin};
            end
        end
    endgenerate

    assign level = pipe[STAGES-1];
endmodule

// File: rtl/csp_regs.sv
module csp_regs
    import csp_pkg::*;
#(
    parameter int RES_W = 24,
    parameter int SH_W  = 24,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       rd_addr,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             rd_done,
    input  logic             cont_en,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic             update_near,
    output logic [SH_W-1:0]  rd_word,
    output logic [CNT_W-1:0] rd_len,
    output logic [SH_W-1:0]  res_al,
    output logic             rdy_n,
    output logic [1:0]       rej_sel
);
    logic [CFG_W-1:0]  mode_q;
    logic [CFG_W-1:0]  conf_q;
    logic [RES_W-1:0]  res_q;
    logic              rdy_q;
    logic [STAT_W-1:0] status;
    logic [SH_W-1:0]   val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= CFG_W'(16'h000A);
            conf_q <= '0;
            res_q  <= '0;
            rdy_q  <= 1'b1;
        end else begin
            if (wr_en && wr_addr == ADDR_MODE) mode_q <= wr_data;
            if (wr_en && wr_addr == ADDR_CONF) conf_q <= wr_data;
            if (conv_done) begin
                res_q <= conv_result;
                rdy_q <= 1'b0;
            end else if (rd_done || update_near) begin
                rdy_q <= 1'b1;
            end
        end
    end

    assign status = {rdy_q, cont_en, 6'b000000};

    always_comb begin
        case (rd_addr)
            ADDR_STAT: begin val = SH_W'(status); rd_len = CNT_W'(STAT_W); end
            ADDR_MODE: begin val = SH_W'(mode_q); rd_len = CNT_W'(CFG_W);  end
            ADDR_CONF: begin val = SH_W'(conf_q); rd_len = CNT_W'(CFG_W);  end
            ADDR_DATA: begin val = SH_W'(res_q);  rd_len = CNT_W'(RES_W);  end
            default:   begin val = '0;            rd_len = CNT_W'(STAT_W); end
        endcase
        rd_word = val << (SH_W - int'(rd_len));
    end

    assign res_al = SH_W'(res_q) << (SH_W - RES_W);
    assign rdy_n  = rdy_q;

    always_comb begin
        case (mode_q[3:0])
            4'b1000: rej_sel = 2'd1;
            4'b1001: rej_sel = 2'd2;
            4'b1010: rej_sel = 2'd3;
            default: rej_sel = 2'd0;
        endcase
    end
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
    import csp_pkg::*;
#(
    parameter int RES_W       = 24,
    parameter int SYNC_STAGES = 2,
    parameter int RST_ONES    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic             update_near,
    output logic             sdo,
    output logic             sdo_en,
    output logic [1:0]       rej_sel
);
    localparam int SH_W   = (RES_W > CFG_W) ? RES_W : CFG_W;
    localparam int CNT_W  = $clog2(SH_W + 1);
    localparam int ONES_W = $clog2(RST_ONES + 1);

    port_state_t      state;
    logic             cs_s, sck_s, din_s, sck_d;
    logic             sck_rise, sck_fall, ones_hit;
    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] bitcnt;
    logic [ONES_W-1:0] ones_cnt;
    logic [2:0]       addr_q;
    logic             cont_q, sdo_q;
    logic             wr_en_q, rd_done_q;
    logic [CFG_W-1:0] wr_data_q;
    logic [SH_W-1:0]  rd_word, res_al;
    logic [CNT_W-1:0] rd_len;
    logic             rdy_n;
    logic             cmd_guard, cmd_read, cmd_cont;
    logic [2:0]       cmd_addr;

    csp_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .pin(sel_n), .level(cs_s));
    csp_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .pin(sclk), .level(sck_s));
    csp_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .pin(sdi), .level(din_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b1;
        else        sck_d <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign ones_hit = ~cs_s & sck_rise & din_s & (ones_cnt == ONES_W'(RST_ONES - 1));

    // Command byte fields seen at the eighth rising edge: {sh[6:0], din_s}
    assign cmd_guard = sh[6];
    assign cmd_read  = sh[5];
    assign cmd_addr  = sh[4:2];
    assign cmd_cont  = sh[1];

    csp_regs #(.RES_W(RES_W), .SH_W(SH_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_addr(cmd_addr),
        .wr_en(wr_en_q), .wr_addr(addr_q), .wr_data(wr_data_q),
        .rd_done(rd_done_q), .cont_en(cont_q),
        .conv_done(conv_done), .conv_result(conv_result),
        .update_near(update_near), .rd_word(rd_word), .rd_len(rd_len),
        .res_al(res_al), .rdy_n(rdy_n), .rej_sel(rej_sel));

    // State register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_CMD;
            sh        <= '0;
            bitcnt    <= '0;
            ones_cnt  <= '0;
            addr_q    <= ADDR_STAT;
            cont_q    <= 1'b0;
            sdo_q     <= 1'b1;
            wr_en_q   <= 1'b0;
            rd_done_q <= 1'b0;
            wr_data_q <= '0;
        end else begin
            wr_en_q   <= 1'b0;
            rd_done_q <= 1'b0;
            if (cs_s) begin
                state    <= ST_CMD;
                bitcnt   <= '0;
                ones_cnt <= '0;
            end else if (ones_hit) begin
                state    <= ST_CMD;
                bitcnt   <= '0;
                ones_cnt <= '0;
                cont_q   <= 1'b0;
            end else begin
                if (sck_rise) ones_cnt <= din_s ? ones_cnt + 1'b1 : '0;
                unique case (state)
                    ST_CMD: begin
                        if (sck_rise) begin
                            sh     <= {sh[SH_W-2:0], din_s};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == CNT_W'(7)) begin
                                bitcnt <= '0;
                                if (!cmd_guard && cmd_read) begin
                                    sh     <= rd_word;
                                    bitcnt <= rd_len;
                                    addr_q <= cmd_addr;
                                    state  <= ST_READ;
                                    if (cmd_addr == ADDR_DATA && cmd_cont) cont_q <= 1'b1;
                                end else if (!cmd_guard &&
                                             (cmd_addr == ADDR_MODE || cmd_addr == ADDR_CONF)) begin
                                    bitcnt <= CNT_W'(CFG_W);
                                    addr_q <= cmd_addr;
                                    state  <= ST_WRITE;
                                end
                            end
                        end
                    end
                    ST_WRITE: begin
                        if (sck_rise) begin
                            sh     <= {sh[SH_W-2:0], din_s};
                            bitcnt <= bitcnt - 1'b1;
                            if (bitcnt == CNT_W'(1)) begin
                                wr_data_q <= {sh[CFG_W-2:0], din_s};
                                wr_en_q   <= 1'b1;
                                state     <= ST_CMD;
                                bitcnt    <= '0;
                            end
                        end
                    end
                    ST_READ: begin
                        if (sck_fall && bitcnt != '0) begin
                            sdo_q  <= sh[SH_W-1];
                            sh     <= sh << 1;
                            bitcnt <= bitcnt - 1'b1;
                        end else if (sck_rise && bitcnt == '0) begin
                            rd_done_q <= (addr_q == ADDR_DATA);
                            state     <= cont_q ? ST_CONT : ST_CMD;
                        end
                    end
                    ST_CONT: begin
                        if (sck_fall && !rdy_n) begin
                            sdo_q  <= res_al[SH_W-1];
                            sh     <= res_al << 1;
                            bitcnt <= CNT_W'(RES_W - 1);
                            addr_q <= ADDR_DATA;
                            state  <= ST_READ;
                        end
                    end
                endcase
            end
        end
    end

    // Output process
    always_comb begin
        sdo_en = ~cs_s;
        sdo    = (state == ST_READ) ? sdo_q : rdy_n;
    end
endmodule

// File: rtl/csp_checker.sv
module csp_checker
    import csp_pkg::*;
#(
    parameter int SH_W  = 24,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_done,
    input logic             update_near,
    input logic             rd_done,
    input logic             rdy_n,
    input logic             sdo_en,
    input port_state_t      state,
    input logic             ones_hit,
    input logic             cont_q,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [3:0]       wr_rate,
    input logic [1:0]       rej_sel,
    input logic [CNT_W-1:0] bitcnt
);
    assert_flag_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !rdy_n);

    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !conv_done) |=> rdy_n);

    assert_flag_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (update_near && !conv_done) |=> rdy_n);

    assert_shift_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bitcnt) <= SH_W);

    assert_rate_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_MODE && wr_rate == 4'b1001) |=> rej_sel == 2'd2);

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |=> state == ST_CMD);

    assert_resync_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ones_hit |=> (state == ST_CMD && !cont_q));
endmodule

bind conv_serial_port csp_checker #(.SH_W(SH_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .update_near(update_near),
    .rd_done(rd_done_q), .rdy_n(rdy_n), .sdo_en(sdo_en), .state(state),
    .ones_hit(ones_hit), .cont_q(cont_q), .wr_en(wr_en_q), .wr_addr(addr_q),
    .wr_rate(wr_data_q[3:0]), .rej_sel(rej_sel), .bitcnt(bitcnt));

// File: tb/conv_serial_port_bench.sv
module conv_serial_port_bench;
    localparam int RES_W = 24;
    localparam int HALF  = 8;

    logic             clk = 1'b0;
    logic             rst_n, sel_n, sclk, sdi, conv_done, update_near;
    logic [RES_W-1:0] conv_result;
    logic             sdo, sdo_en;
    logic [1:0]       rej_sel;
    int               checks = 0;
    int               errors = 0;

    always #5 clk = ~clk;

    conv_serial_port #(.RES_W(RES_W)) u_conv_serial_port (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
        .conv_done(conv_done), .conv_result(conv_result),
        .update_near(update_near), .sdo(sdo), .sdo_en(sdo_en), .rej_sel(rej_sel));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic o);
        @(negedge clk);
        sclk = 1'b0;
        sdi  = b;
        repeat (HALF) @(negedge clk);
        o    = sdo;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic shift_n(input logic [31:0] w, input int n, output logic [31:0] r);
        logic o;
        r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            bit_io(w[i], o);
            r[i] = o;
        end
        sdi = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, input int n, input logic c, output logic [31:0] r);
        logic [31:0] dummy;
        shift_n({24'h0, 2'b01, a, c, 2'b00}, 8, dummy);
        shift_n(32'h0, n, r);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] v);
        logic [31:0] dummy;
        shift_n({24'h0, 2'b00, a, 3'b000}, 8, dummy);
        shift_n({16'h0, v}, 16, dummy);
    endtask

    task automatic conv(input logic [RES_W-1:0] v);
        @(negedge clk);
        conv_done   = 1'b1;
        conv_result = v;
        @(negedge clk);
        conv_done   = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [1:0] rej_exp(input logic [3:0] c);
        return (c == 4'd8) ? 2'd1 : (c == 4'd9) ? 2'd2 : (c == 4'd10) ? 2'd3 : 2'd0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [23:0] pats [5];
        logic [15:0] mv;
        pats = '{24'h800000, 24'h000000, 24'hFFFFFF, 24'h7FFFFF, 24'hA5A5A5};
        rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
        conv_done = 1'b0; update_near = 1'b0; conv_result = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 reset sdo_en", {31'h0, sdo_en}, 32'h0);
        check("R9 reset rej_sel", {30'h0, rej_sel}, 32'h3);

        sel_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R10 select low enables", {31'h0, sdo_en}, 32'h1);
        check("R2 idle flag high", {31'h0, sdo}, 32'h1);
        conv(24'h123456);
        check("R2 flag low after result", {31'h0, sdo}, 32'h0);

        rd_reg(3'd0, 8, 1'b0, r);
        check("R7 status read", r, 32'h00);
        repeat (4) @(negedge clk);
        check("R3 status read keeps flag", {31'h0, sdo}, 32'h0);
        rd_reg(3'd3, 24, 1'b0, r);
        check("R1 R3 data read", r, 32'h123456);
        repeat (4) @(negedge clk);
        check("R3 flag high after read", {31'h0, sdo}, 32'h1);
        rd_reg(3'd3, 24, 1'b0, r);
        check("R3 re-read same word", r, 32'h123456);

        foreach (pats[i]) begin
            conv(pats[i]);
            rd_reg(3'd3, 24, 1'b0, r);
            check("R12 offset-binary word", r, {8'h0, pats[i]});
        end

        for (int c = 0; c < 16; c++) begin
            mv = 16'h3100 | 16'(c);
            wr_reg(3'd1, mv);
            repeat (4) @(negedge clk);
            check("R9 rate decode", {30'h0, rej_sel}, {30'h0, rej_exp(4'(c))});
            rd_reg(3'd1, 16, 1'b0, r);
            check("R8 mode read-back", r, {16'h0, mv});
        end
        wr_reg(3'd2, 16'hA5C3);
        rd_reg(3'd2, 16, 1'b0, r);
        check("R8 config read-back", r, 32'hA5C3);

        shift_n(32'h00, 8, r);
        rd_reg(3'd2, 16, 1'b0, r);
        check("R7 status write has no data phase", r, 32'hA5C3);
        shift_n(32'h18, 8, r);
        rd_reg(3'd3, 24, 1'b0, r);
        check("R7 data write ignored", r, 32'hA5A5A5);

        shift_n(32'hD0, 8, r);
        rd_reg(3'd2, 16, 1'b0, r);
        check("R6 guarded read ignored", r, 32'hA5C3);
        shift_n(32'h88, 8, r);
        rd_reg(3'd1, 16, 1'b0, r);
        check("R6 guarded write ignored", r, 32'h310F);

        conv(24'h0F0F0F);
        check("R2 flag low", {31'h0, sdo}, 32'h0);
        @(negedge clk); update_near = 1'b1;
        @(negedge clk); update_near = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 flag rearmed unread", {31'h0, sdo}, 32'h1);
        rd_reg(3'd3, 24, 1'b0, r);
        check("R3 unread word still readable", r, 32'h0F0F0F);

        conv(24'h111111);
        rd_reg(3'd3, 24, 1'b1, r);
        check("R5 entering continuous read", r, 32'h111111);
        conv(24'h2468AC);
        shift_n(32'h0, 24, r);
        check("R5 unframed word", r, 32'h2468AC);
        shift_n(32'h0, 24, r);
        check("R5 word given once", r, 32'hFFFFFF);
        conv(24'h13579B);
        shift_n(32'h0, 24, r);
        check("R5 next unframed word", r, 32'h13579B);

        shift_n(32'hFFFFFFFF, 32, r);
        rd_reg(3'd2, 16, 1'b0, r);
        check("R11 command after resync", r, 32'hA5C3);
        conv(24'hABCDEF);
        shift_n(32'h0, 24, r);
        check("R11 continuous mode left", r, 32'h0);
        rd_reg(3'd3, 24, 1'b0, r);
        check("R11 framed read after resync", r, 32'hABCDEF);

        shift_n(32'h5, 4, r);
        sel_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 released pin", {31'h0, sdo_en}, 32'h0);
        sel_n = 1'b0;
        repeat (6) @(negedge clk);
        rd_reg(3'd2, 16, 1'b0, r);
        check("R10 partial command dropped", r, 32'hA5C3);
        shift_n(32'h10, 8, r);
        shift_n(32'hFF, 8, r);
        sel_n = 1'b1;
        repeat (6) @(negedge clk);
        sel_n = 1'b0;
        repeat (6) @(negedge clk);
        rd_reg(3'd2, 16, 1'b0, r);
        check("R10 partial write dropped", r, 32'hA5C3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule